// File: doc/BRIEF.md
# Interleaved I/Q Input Pair Assembler

This block sits between a baseband sample source and a digital quadrature modulator. It takes 16-bit words from one or two parallel input ports and delivers aligned in-phase/quadrature pairs, in two's complement, marked by a one-cycle valid pulse. When both ports are in use, each qualified cycle carries a whole pair: the I word on port A and the Q word on port B. When one port is in use, I and Q words alternate on port A at twice the pair rate. A select strobe, whose polarity can be set, labels each word. The block keeps one partial word until its partner arrives.

Static configuration inputs choose the port mode, the strobe polarity, the pairing order and the input number format. In the normal order, an I word waits for the Q word that follows it. In the Q-first order, a Q word waits for the next I word. The first I word of a stream therefore has no partner. A real-only control forces the Q output to zero. Changing the mode, polarity or pairing order discards any half-built pair. A synchronous clear does the same.

Top module: `iq_pair_assembler`

## Requirements
- R1: While rstN is low and after its release, pairValid is 0 and outI and outQ are 0 until the first pair is emitted.
- R2: With cfgSinglePort = 0, every cycle with inValid = 1 gives pairValid = 1 in the next cycle, with outI taken from portA and outQ taken from portB of that cycle.
- R3: With cfgSinglePort = 1, a qualified word on portA is an I word when selStrobe XOR cfgSelInvert is 1 and a Q word when it is 0. So with cfgSelInvert = 0 a high strobe marks I, and with cfgSelInvert = 1 a low strobe marks I.
- R4: With cfgSinglePort = 1 and cfgQFirst = 0, an I word is held. The next Q word emits the pair (held I, that Q) in the cycle after the Q word.
- R5: With cfgSinglePort = 1 and cfgQFirst = 1, a Q word is held. The next I word emits (that I, held Q), so the stream I0,Q0,I1,Q1,I2 gives (I1,Q0),(I2,Q1), and the first I word produces nothing.
- R6: In single-port mode, a second word of the held kind replaces the held word. A word of the partner kind with nothing held is discarded, and neither case pulses pairValid.
- R7: With cfgOffsetBin = 1, bit 15 of each emitted word is inverted (offset binary to two's complement). With cfgOffsetBin = 0, words pass unchanged. The setting in force in the emitting cycle applies.
- R8: With cfgRealMode = 1, an emitted pair has outQ = 0 and outI unchanged.
- R9: A cycle with syncClear = 1 discards the held word, ignores that cycle's input and emits nothing.
- R10: A cycle in which {cfgSinglePort, cfgSelInvert, cfgQFirst} differs from its value in the previous cycle discards the held word and then handles that cycle's word as if nothing were held. The reference value after reset is all zeros.
- R11: pairValid is 1 only in the cycle after an accepted completing word. In all other cycles it is 0, and outI and outQ keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncClear | input | 1 | Synchronous clear of a partial pair |
| cfgSinglePort | input | 1 | 1: interleaved words on portA; 0: I on portA, Q on portB |
| cfgSelInvert | input | 1 | Inverts the meaning of selStrobe |
| cfgQFirst | input | 1 | 1: each I pairs with the preceding Q |
| cfgOffsetBin | input | 1 | 1: input words are offset binary |
| cfgRealMode | input | 1 | 1: Q output forced to zero |
| inValid | input | 1 | Input word(s) present this cycle |
| selStrobe | input | 1 | I/Q marker for single-port words |
| portA | input | 16 | Port A data |
| portB | input | 16 | Port B data (dual-port Q) |
| pairValid | output | 1 | One-cycle pulse for a new pair |
| outI | output | 16 | I sample, two's complement |
| outQ | output | 16 | Q sample, two's complement |

## Verification
Dual-port streams confirm that the two ports land on the correct outputs, and that they do so under both number formats and in real-only mode. Strictly alternating single-port streams are run under both strobe polarities and both pairing orders. These runs show the difference between pairing I with the Q after it and pairing it with the Q before it, including the lone leading I word. Streams with repeated or orphan words, clears and mid-pair configuration flips show whether the held word is replaced, dropped or kept. Long random runs mix all of these against a bench reference model.

// File: rtl/iq_asm_pkg.sv
package iq_asm_pkg;

  typedef enum logic [1:0] {
    SRC_DUAL   = 2'd0,
    SRC_HELD_I = 2'd1,
    SRC_HELD_Q = 2'd2
  } pair_src_e;

  typedef struct packed {
    logic      loadHold;
    logic      emitPair;
    pair_src_e pairSrc;
  } asm_ctrl_t;

endpackage

// File: rtl/iq_asm_ctrl.sv
module iq_asm_ctrl
  import iq_asm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      syncClear,
  input  logic      cfgSinglePort,
  input  logic      cfgSelInvert,
  input  logic      cfgQFirst,
  input  logic      inValid,
  input  logic      selStrobe,
  output asm_ctrl_t ctrlStrb
);

  localparam int CFG_W = 3;

  logic [CFG_W-1:0] prevCfg;
  logic [CFG_W-1:0] cfgNow;
  logic             holdValid;
  logic             holdNext;
  logic             cfgChanged;
  logic             heldLive;
  logic             isIWord;
  logic             isHoldKind;

  always_comb begin
    cfgNow     = {cfgSinglePort, cfgSelInvert, cfgQFirst};
    cfgChanged = (cfgNow != prevCfg);
    heldLive   = holdValid && !cfgChanged;
    isIWord    = selStrobe ^ cfgSelInvert;
    isHoldKind = cfgQFirst ? !isIWord : isIWord;

    ctrlStrb          = '0;
    ctrlStrb.pairSrc  = SRC_DUAL;
    holdNext          = heldLive;

    if (syncClear) begin
      holdNext = 1'b0;
    end else if (inValid) begin
      if (!cfgSinglePort) begin
        ctrlStrb.emitPair = 1'b1;
        ctrlStrb.pairSrc  = SRC_DUAL;
      end else if (isHoldKind) begin
        ctrlStrb.loadHold = 1'b1;
        holdNext          = 1'b1;
      end else if (heldLive) begin
        ctrlStrb.emitPair = 1'b1;
        ctrlStrb.pairSrc  = cfgQFirst ? SRC_HELD_Q : SRC_HELD_I;
        holdNext          = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCfg   <= '0;
      holdValid <= 1'b0;
    end else begin
      prevCfg   <= cfgNow;
      holdValid <= holdNext;
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    syncClear |=> !holdValid); // R9

  AST_DUAL_NEVER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSinglePort |=> !holdValid); // R2

  AST_ORPHAN_NO_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSinglePort && !holdValid) |-> !ctrlStrb.emitPair); // R6

  AST_CFG_FLIP_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSinglePort && (cfgNow != prevCfg) && !isHoldKind) |-> !ctrlStrb.emitPair); // R10

endmodule

// File: rtl/iq_fmt_conv.sv
module iq_fmt_conv #(
  parameter int DATA_W = 16
) (
  input  logic              offsetBin,
  input  logic              zeroOut,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    if (zeroOut)        dout = '0;
    else if (offsetBin) dout = din ^ SIGN_MASK;
    else                dout = din;
  end

endmodule

// File: rtl/iq_asm_datapath.sv
module iq_asm_datapath
  import iq_asm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  asm_ctrl_t         ctrlStrb,
  input  logic              cfgOffsetBin,
  input  logic              cfgRealMode,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  output logic              pairValid,
  output logic [DATA_W-1:0] outI,
  output logic [DATA_W-1:0] outQ
);

  localparam int LANES = 2;

  logic [DATA_W-1:0] holdWord;
  logic [DATA_W-1:0] laneRaw [LANES];
  logic [DATA_W-1:0] laneCvt [LANES];

  always_comb begin
    unique case (ctrlStrb.pairSrc)
      SRC_HELD_I: begin laneRaw[0] = holdWord; laneRaw[1] = portA;    end
      SRC_HELD_Q: begin laneRaw[0] = portA;    laneRaw[1] = holdWord; end
      default:    begin laneRaw[0] = portA;    laneRaw[1] = portB;    end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iq_fmt_conv #(.DATA_W(DATA_W)) u_conv (
      .offsetBin (cfgOffsetBin),
      .zeroOut   ((g == 1) && cfgRealMode),
      .din       (laneRaw[g]),
      .dout      (laneCvt[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord  <= '0;
      pairValid <= 1'b0;
      outI      <= '0;
      outQ      <= '0;
    end else begin
      pairValid <= ctrlStrb.emitPair;
      if (ctrlStrb.loadHold) holdWord <= portA;
      if (ctrlStrb.emitPair) begin
        outI <= laneCvt[0];
        outQ <= laneCvt[1];
      end
    end
  end

  AST_VALID_TRACKS_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStrb.emitPair |=> pairValid); // R2

  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlStrb.emitPair |=> !pairValid); // R11

  AST_REAL_Q_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && $past(cfgRealMode)) |-> (outQ == '0)); // R8

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !pairValid |-> ($stable(outI) && $stable(outQ))); // R11

endmodule

// File: rtl/iq_pair_assembler.sv
module iq_pair_assembler
  import iq_asm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncClear,
  input  logic              cfgSinglePort,
  input  logic              cfgSelInvert,
  input  logic              cfgQFirst,
  input  logic              cfgOffsetBin,
  input  logic              cfgRealMode,
  input  logic              inValid,
  input  logic              selStrobe,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  output logic              pairValid,
  output logic [DATA_W-1:0] outI,
  output logic [DATA_W-1:0] outQ
);

  asm_ctrl_t ctrlStrb;

  iq_asm_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .syncClear     (syncClear),
    .cfgSinglePort (cfgSinglePort),
    .cfgSelInvert  (cfgSelInvert),
    .cfgQFirst     (cfgQFirst),
    .inValid       (inValid),
    .selStrobe     (selStrobe),
    .ctrlStrb      (ctrlStrb)
  );

  iq_asm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlStrb     (ctrlStrb),
    .cfgOffsetBin (cfgOffsetBin),
    .cfgRealMode  (cfgRealMode),
    .portA        (portA),
    .portB        (portB),
    .pairValid    (pairValid),
    .outI         (outI),
    .outQ         (outQ)
  );

  AST_PULSE_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> ($past(inValid) && !$past(syncClear))); // R11

endmodule

// File: tb/iq_pair_assembler_bench.sv
module iq_pair_assembler_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          syncClear = 1'b0;
  logic          cfgSinglePort = 1'b0;
  logic          cfgSelInvert = 1'b0;
  logic          cfgQFirst = 1'b0;
  logic          cfgOffsetBin = 1'b0;
  logic          cfgRealMode = 1'b0;
  logic          inValid = 1'b0;
  logic          selStrobe = 1'b0;
  logic [DW-1:0] portA = '0;
  logic [DW-1:0] portB = '0;
  logic          pairValid;
  logic [DW-1:0] outI;
  logic [DW-1:0] outQ;

  int total = 0;
  int bad = 0;

  logic          mHv;
  logic [DW-1:0] mHw;
  logic [2:0]    mPrev;
  logic          expV;
  logic [DW-1:0] expI;
  logic [DW-1:0] expQ;
  string         lastTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_pair_assembler u_iq_pair_assembler (
    .clk(clk), .rstN(rstN), .syncClear(syncClear),
    .cfgSinglePort(cfgSinglePort), .cfgSelInvert(cfgSelInvert),
    .cfgQFirst(cfgQFirst), .cfgOffsetBin(cfgOffsetBin), .cfgRealMode(cfgRealMode),
    .inValid(inValid), .selStrobe(selStrobe), .portA(portA), .portB(portB),
    .pairValid(pairValid), .outI(outI), .outQ(outQ)
  );

  function automatic logic [DW-1:0] fmt(input logic [DW-1:0] w, input logic ob);
    return ob ? (w ^ 16'h8000) : w;
  endfunction

  task automatic expectEmit(input logic [DW-1:0] iw, input logic [DW-1:0] qw);
    expV = 1'b1;
    expI = fmt(iw, cfgOffsetBin);
    expQ = cfgRealMode ? '0 : fmt(qw, cfgOffsetBin);
  endtask

  task automatic modelStep();
    logic [2:0] cfgNow;
    logic isI, hk;
    cfgNow = {cfgSinglePort, cfgSelInvert, cfgQFirst};
    expV = 1'b0;
    if (syncClear) mHv = 1'b0;
    else begin
      if (cfgNow != mPrev) mHv = 1'b0;
      if (inValid) begin
        if (!cfgSinglePort) expectEmit(portA, portB);
        else begin
          isI = selStrobe ^ cfgSelInvert;
          hk  = cfgQFirst ? !isI : isI;
          if (hk) begin mHw = portA; mHv = 1'b1; end
          else if (mHv) begin
            if (cfgQFirst) expectEmit(portA, mHw);
            else           expectEmit(mHw, portA);
            mHv = 1'b0;
          end
        end
      end
    end
    mPrev = cfgNow;
  endtask

  task automatic check(input string tag);
    total++;
    if (pairValid !== expV) begin
      bad++;
      $display("FAIL %s pairValid actual=%0b expected=%0b", tag, pairValid, expV);
    end
    total++;
    if (outI !== expI || outQ !== expQ) begin
      bad++;
      $display("FAIL %s pair actual=%h/%h expected=%h/%h", tag, outI, outQ, expI, expQ);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic s,
                      input logic [DW-1:0] a, input logic [DW-1:0] b);
    inValid = v; selStrobe = s; portA = a; portB = b;
    modelStep();
    @(negedge clk);
    check(tag);
    syncClear = 1'b0;
  endtask

  task automatic idle();
    step("R11 idle", 1'b0, 1'b0, 16'h0, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    mHv = 0; mHw = 0; mPrev = 0; expV = 0; expI = 0; expQ = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R2 dual port, both formats, real mode
    step("R2 dual", 1, 0, 16'h1234, 16'hABCD);
    step("R2 dual", 1, 1, 16'h8001, 16'h7FFE);
    idle();
    cfgOffsetBin = 1;
    step("R7 offset dual", 1, 0, 16'h8000, 16'h0123);
    cfgOffsetBin = 0; cfgRealMode = 1;
    step("R8 real dual", 1, 0, 16'h5555, 16'hAAAA);
    cfgRealMode = 0;
    idle();

    // R3/R4 single port normal pairing, both polarities
    cfgSinglePort = 1;
    idle();
    step("R4 hold I", 1, 1, 16'h1111, 16'h0);
    step("R4 pair", 1, 0, 16'h2222, 16'h0);
    cfgSelInvert = 1;
    idle();
    step("R3 inv I", 1, 0, 16'h3333, 16'h0);
    step("R3 inv pair", 1, 1, 16'h4444, 16'h0);
    cfgSelInvert = 0;
    idle();

    // R6 replace and orphan
    step("R6 I", 1, 1, 16'h0A0A, 16'h0);
    step("R6 replace I", 1, 1, 16'h0B0B, 16'h0);
    step("R6 pair", 1, 0, 16'h0C0C, 16'h0);
    step("R6 orphan Q", 1, 0, 16'h0D0D, 16'h0);
    idle();

    // R5 Q-first pairing
    cfgQFirst = 1;
    idle();
    step("R5 lone I0", 1, 1, 16'h1000, 16'h0);
    step("R5 Q0", 1, 0, 16'h2000, 16'h0);
    step("R5 I1 pair", 1, 1, 16'h1001, 16'h0);
    step("R5 Q1", 1, 0, 16'h2001, 16'h0);
    step("R5 I2 pair", 1, 1, 16'h1002, 16'h0);
    cfgQFirst = 0;
    idle();

    // R9 clear between I and Q
    step("R9 I", 1, 1, 16'h7777, 16'h0);
    syncClear = 1;
    step("R9 clear ignores word", 1, 1, 16'h7778, 16'h0);
    step("R9 Q no pair", 1, 0, 16'h8888, 16'h0);

    // R10 config flip drops held word; flip-cycle word taken fresh
    step("R10 I", 1, 1, 16'h9999, 16'h0);
    cfgSelInvert = 1;
    step("R10 flip, now Q orphan", 1, 1, 16'h9A9A, 16'h0);
    step("R10 I", 1, 0, 16'h9B9B, 16'h0);
    cfgSelInvert = 0;
    step("R10 flip, fresh I", 1, 1, 16'h9C9C, 16'h0);
    step("R10 pair", 1, 0, 16'h9D9D, 16'h0);
    cfgOffsetBin = 1;
    step("R7 offset single I", 1, 1, 16'h0001, 16'h0);
    step("R7 offset single pair", 1, 0, 16'hFFFF, 16'h0);
    cfgOffsetBin = 0;

    // random mix
    for (int n = 0; n < 4000; n++) begin
      string tg;
      logic s;
      if ($urandom_range(99) < 2) cfgSinglePort = ~cfgSinglePort;
      if ($urandom_range(99) < 2) cfgSelInvert  = ~cfgSelInvert;
      if ($urandom_range(99) < 2) cfgQFirst     = ~cfgQFirst;
      if ($urandom_range(99) < 3) cfgOffsetBin  = ~cfgOffsetBin;
      if ($urandom_range(99) < 3) cfgRealMode   = ~cfgRealMode;
      syncClear = ($urandom_range(99) < 3);
      s = (n % 2 == 0);
      if ($urandom_range(99) < 10) s = ~s;
      if (!cfgSinglePort) tg = "R2 random dual";
      else if (cfgQFirst) tg = "R5 random qfirst";
      else                tg = "R4 random normal";
      step(tg, ($urandom_range(99) < 80), s ^ cfgSelInvert,
           16'($urandom), 16'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule